// File: doc/BRIEF.md
# I2C Command Transfer Sequencer

This block runs one complete I2C controller transaction, at byte level, from a single command word. Once the command is accepted, the sequencer pulls address and data bytes from a transmit FIFO and pushes received bytes into a receive FIFO. It drives a byte-level bus engine by requesting start, repeated start, byte write, byte read (with the ACK or NACK to return) and stop. The engine reports each finished operation and the acknowledge it saw.

A command selects a plain write, a plain read, or a combined transfer. In a combined transfer, an address phase carries the target address and register-offset bytes, a repeated start follows, the read address is resent, and the data phase runs. The data direction comes from bit 0 of the first byte of the most recent address group. The transaction ends with a one-cycle completion pulse or a one-cycle NACK pulse. An abort input closes the bus with a stop and returns the sequencer to idle without either pulse.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A command is accepted only while idle, when `cmd_valid_i` is high and the command word has bit 15 (execute), bit 11 (controller mode) and bit 0 (sequence enable) set and bits 14:12 clear. Any other word is ignored, so `busy_o` stays low and no bus request appears.
- R2: Bus operation codes on `bus_op_o` are 0 none, 1 start, 2 repeated start, 3 write byte, 4 read byte, 5 stop. Every accepted command first issues a start.
- R3: The address phase writes as many bytes as bits 3:1 of the command give, each popped from the transmit FIFO in order.
- R4: When bit 4 is set, a repeated start follows the address phase, and then the number of bytes given by bits 7:5 are popped and written.
- R5: The data phase runs for the latched data count. If bit 0 of the first byte of the last address group is 0, it pops and writes that many bytes. If that bit is 1, it issues that many reads and pushes each returned byte to the receive FIFO.
- R6: When bit 8 (data-count enable) is clear, the data phase is empty whatever the data count holds.
- R7: When bit 9 is set, the final read of the data phase returns NACK (`bus_ack_o` low) and every earlier read returns ACK. When bit 9 is clear, every read returns ACK.
- R8: A write answered without an acknowledge ends the transfer with a stop and a `nack_o` pulse, and gives no `done_o`, unless `ign_nack_i` was high when the command was accepted.
- R9: A stop is issued at the end of a completed transfer only when bit 10 is set. `done_o` pulses for one cycle after the last operation.
- R10: While the transmit FIFO is empty and a byte is needed, no bus request is driven and nothing is popped. The sequence resumes when data arrives.
- R11: A bus request holds its operation code and write byte unchanged until the engine reports it finished.
- R12: An abort lets the operation in flight finish, then issues a stop and returns to idle with neither `done_o` nor `nack_o`.
- R13: `done_o` and `nack_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_i | input | 16 | Command word |
| dcnt_i | input | DCNT_W | Data-phase byte count, latched with the command |
| ign_nack_i | input | 1 | Ignore missing acknowledges, latched with the command |
| abort_i | input | 1 | Abort the running transaction |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Pop the transmit FIFO head |
| rx_data_o | output | 8 | Byte to the receive FIFO |
| rx_push_o | output | 1 | Push to the receive FIFO |
| bus_req_o | output | 1 | Bus engine request |
| bus_op_o | output | 3 | Requested bus operation |
| bus_wdata_o | output | 8 | Byte to write |
| bus_ack_o | output | 1 | Acknowledge to return on a read (1 = ACK) |
| bus_done_i | input | 1 | Bus operation finished (one-cycle pulse) |
| bus_rack_i | input | 1 | Acknowledge seen on the finished write (1 = ACK) |
| bus_rdata_i | input | 8 | Byte returned by a finished read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Command-complete pulse |
| nack_o | output | 1 | NACK-received pulse |

## Verification
A wrong phase counter or phase register shows up on the bus operation stream within one engine round trip: a byte too many or too few, a missing repeated start, or reads where writes belong. A mislatched direction bit turns the whole data phase over at its first operation. A wrong end flag shows up on the end pulses in the cycle after the final stop. Stall and abort faults show up as requests that appear while the FIFO is empty, or as a stop that never comes, so the bench bounds the time from abort to idle.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int CMD_W = 16;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_NEXT, ST_FETCH, ST_WRITE,
    ST_READ, ST_RSTART, ST_STOP, ST_END
  } seq_state_e;

  typedef enum logic [1:0] {PH_ADDR, PH_RADDR, PH_DATA} phase_e;

  typedef struct packed {
    logic [2:0] alen;
    logic [2:0] ralen;
    logic       rs_en;
    logic       dc_en;
    logic       nack_last;
    logic       stop_en;
  } seq_cfg_t;

  function automatic logic cmd_ok(logic [CMD_W-1:0] c);
    return c[15] && c[11] && c[0] && (c[14:12] == 3'b000);
  endfunction

  function automatic seq_cfg_t cmd_decode(logic [CMD_W-1:0] c);
    seq_cfg_t r;
    r.alen      = c[3:1];
    r.rs_en     = c[4];
    r.ralen     = c[7:5];
    r.dc_en     = c[8];
    r.nack_last = c[9];
    r.stop_en   = c[10];
    return r;
  endfunction

endpackage

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
  import i2c_seq_pkg::*;
#(
  parameter int DCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DCNT_W-1:0] dcnt_i,
  input  logic              ign_nack_i,
  output logic              start_o,
  output seq_cfg_t          cfg_o,
  output logic [DCNT_W-1:0] dcnt_o,
  output logic              ign_o
);

  assign start_o = idle_i && cmd_valid_i && cmd_ok(cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      dcnt_o <= '0;
      ign_o  <= 1'b0;
    end else if (start_o) begin
      cfg_o  <= cmd_decode(cmd_i);
      dcnt_o <= dcnt_i;
      ign_o  <= ign_nack_i;
    end
  end

endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         one_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));

  // R5: a byte is never counted past the end of its phase
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);

endmodule

// File: rtl/i2c_seq_busif.sv
module i2c_seq_busif
  import i2c_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e st_i,
  input  logic       pop_i,
  input  logic [7:0] tx_data_i,
  input  logic       nack_last_i,
  input  logic       last_i,
  input  logic       bus_done_i,
  output logic       bus_req_o,
  output logic [2:0] bus_op_o,
  output logic [7:0] bus_wdata_o,
  output logic       bus_ack_o
);

  bus_op_e op;

  always_comb begin
    unique case (st_i)
      ST_START:  op = OP_START;
      ST_RSTART: op = OP_RSTART;
      ST_WRITE:  op = OP_WRITE;
      ST_READ:   op = OP_READ;
      ST_STOP:   op = OP_STOP;
      default:   op = OP_NONE;
    endcase
  end

  assign bus_op_o  = op;
  assign bus_req_o = (op != OP_NONE);
  assign bus_ack_o = !(nack_last_i && last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bus_wdata_o <= 8'h00;
    else if (pop_i) bus_wdata_o <= tx_data_i;
  end

  // R11: request held until the engine finishes it
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=>
      (bus_req_o && $stable(bus_op_o) && $stable(bus_wdata_o) && $stable(bus_ack_o)));

  // R10: no new byte taken while a request is outstanding
  a_r10_pop_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !bus_req_o);

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int DCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [15:0]       cmd_i,
  input  logic [DCNT_W-1:0] dcnt_i,
  input  logic              ign_nack_i,
  input  logic              abort_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_push_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_op_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_ack_o,
  input  logic              bus_done_i,
  input  logic              bus_rack_i,
  input  logic [7:0]        bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              nack_o
);

  localparam int CW   = (DCNT_W < 3) ? 3 : DCNT_W;
  localparam int PADW = CW - 3;

  seq_state_e   st_q, st_d;
  phase_e       ph_q, ph_d;
  logic         abort_q, nack_q, dir_q, first_q;
  logic         start, ign_q;
  seq_cfg_t     cfg;
  logic [DCNT_W-1:0] dcnt_q;
  logic [CW-1:0] load_val, dcnt_eff;
  logic         load, dec, zero, one, pop, nack_set, aborting;

  i2c_seq_cmd #(.DCNT_W(DCNT_W)) u_cmd (
    .clk_i, .rst_ni,
    .idle_i      (st_q == ST_IDLE),
    .cmd_valid_i, .cmd_i, .dcnt_i, .ign_nack_i,
    .start_o     (start),
    .cfg_o       (cfg),
    .dcnt_o      (dcnt_q),
    .ign_o       (ign_q)
  );

  i2c_seq_cnt #(.W(CW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .zero_o     (zero),
    .one_o      (one)
  );

  i2c_seq_busif u_bus (
    .clk_i, .rst_ni,
    .st_i        (st_q),
    .pop_i       (pop),
    .tx_data_i,
    .nack_last_i (cfg.nack_last),
    .last_i      (one),
    .bus_done_i,
    .bus_req_o, .bus_op_o, .bus_wdata_o, .bus_ack_o
  );

  assign aborting = abort_q || abort_i;
  assign pop      = (st_q == ST_FETCH) && !tx_empty_i && !aborting;
  assign dcnt_eff = cfg.dc_en ? CW'(dcnt_q) : '0;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    dec      = 1'b0;
    nack_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_START;
      ST_START: if (bus_done_i) begin
        if (aborting) st_d = ST_STOP;
        else begin
          ph_d = PH_ADDR; load = 1'b1; load_val = {{PADW{1'b0}}, cfg.alen}; st_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (aborting) st_d = ST_STOP;
        else if (!zero) st_d = (ph_q == PH_DATA && dir_q) ? ST_READ : ST_FETCH;
        else begin
          unique case (ph_q)
            PH_ADDR: if (cfg.rs_en) st_d = ST_RSTART;
                     else begin ph_d = PH_DATA; load = 1'b1; load_val = dcnt_eff; end
            PH_RADDR: begin ph_d = PH_DATA; load = 1'b1; load_val = dcnt_eff; end
            default: st_d = cfg.stop_en ? ST_STOP : ST_END;
          endcase
        end
      end
      ST_FETCH: begin
        if (aborting) st_d = ST_STOP;
        else if (!tx_empty_i) st_d = ST_WRITE;
      end
      ST_WRITE: if (bus_done_i) begin
        dec = 1'b1;
        if (aborting) st_d = ST_STOP;
        else if (!bus_rack_i && !ign_q) begin nack_set = 1'b1; st_d = ST_STOP; end
        else st_d = ST_NEXT;
      end
      ST_READ: if (bus_done_i) begin
        dec  = 1'b1;
        st_d = aborting ? ST_STOP : ST_NEXT;
      end
      ST_RSTART: if (bus_done_i) begin
        if (aborting) st_d = ST_STOP;
        else begin
          ph_d = PH_RADDR; load = 1'b1; load_val = {{PADW{1'b0}}, cfg.ralen}; st_d = ST_NEXT;
        end
      end
      ST_STOP: if (bus_done_i) st_d = ST_END;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      abort_q <= 1'b0;
      nack_q  <= 1'b0;
      dir_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (start) begin
        abort_q <= 1'b0;
        nack_q  <= 1'b0;
        dir_q   <= 1'b0;
      end else begin
        if (abort_i && st_q != ST_IDLE) abort_q <= 1'b1;
        if (nack_set) nack_q <= 1'b1;
        // direction follows bit 0 of the first byte of each address group
        if (pop && first_q && ph_q != PH_DATA) dir_q <= tx_data_i[0];
      end
      if (load)     first_q <= (ph_d != PH_DATA);
      else if (pop) first_q <= 1'b0;
    end
  end

  assign tx_pop_o  = pop;
  assign rx_push_o = (st_q == ST_READ) && bus_done_i;
  assign rx_data_o = bus_rdata_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_END) && !nack_q && !abort_q;
  assign nack_o    = (st_q == ST_END) && nack_q && !abort_q;

  // R1: nothing reaches the bus or the FIFO while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_req_o && !tx_pop_o && !rx_push_o));
  // R10: never pop an empty FIFO
  a_r10_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);
  // R13: end pulses exclusive and single-cycle
  a_r13_end_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && nack_o));
  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r13_nack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |=> !nack_o);
  // R12: an abort suppresses any later end report
  a_r12_abort_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!done_o && !nack_o));
  // R5: received bytes only come from read operations
  a_r5_push_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> (bus_op_o == 3'd4));

endmodule

// File: tb/tb_i2c_xfer_seq.sv
`timescale 1ns/1ps
module tb_i2c_xfer_seq;

  localparam int DCNT_W = 8;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cmd_valid_i = 0;
  logic [15:0]       cmd_i = '0;
  logic [DCNT_W-1:0] dcnt_i = '0;
  logic              ign_nack_i = 0, abort_i = 0;
  logic [7:0]        tx_data_i = '0;
  logic              tx_empty_i = 1;
  logic              tx_pop_o, rx_push_o, bus_req_o, bus_ack_o;
  logic [7:0]        rx_data_o, bus_wdata_o;
  logic [2:0]        bus_op_o;
  logic              bus_done_i = 0, bus_rack_i = 1;
  logic [7:0]        bus_rdata_i = '0;
  logic              busy_o, done_o, nack_o;

  i2c_xfer_seq #(.DCNT_W(DCNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i, .cmd_i, .dcnt_i, .ign_nack_i, .abort_i,
    .tx_data_i, .tx_empty_i, .tx_pop_o,
    .rx_data_o, .rx_push_o,
    .bus_req_o, .bus_op_o, .bus_wdata_o, .bus_ack_o,
    .bus_done_i, .bus_rack_i, .bus_rdata_i,
    .busy_o, .done_o, .nack_o
  );

  int n_checks = 0, n_fail = 0, cycles = 0;

  logic [7:0] txq[$];
  logic [2:0] op_log[64];
  logic [7:0] wd_log[64];
  logic       ack_log[64];
  logic [7:0] rx_log[64];
  int n_ops, n_rx, n_done, n_nack, wr_idx, rd_idx, nack_at;
  logic pop_pend = 0, req_s = 0, ack_s = 0;
  logic [2:0] op_s = '0;
  logic [7:0] wd_s = '0;
  int lat = 0;

  // bus engine and FIFO model: drive at negedge, sample 1 ns later
  always @(negedge clk) begin
    cycles++;
    if (pop_pend) begin void'(txq.pop_front()); pop_pend = 0; end
    if (bus_done_i) begin bus_done_i = 0; lat = 0; end
    else if (req_s) begin
      lat++;
      if (lat >= LAT) begin
        bus_done_i = 1;
        if (n_ops < 64) begin op_log[n_ops] = op_s; wd_log[n_ops] = wd_s; ack_log[n_ops] = ack_s; end
        n_ops++;
        if (op_s == 3'd3) begin bus_rack_i = (wr_idx != nack_at); wr_idx++; end
        if (op_s == 3'd4) begin bus_rdata_i = 8'h50 + 8'(rd_idx); rd_idx++; end
      end
    end else lat = 0;
    tx_empty_i = (txq.size() == 0);
    tx_data_i  = tx_empty_i ? 8'h00 : txq[0];
    #1;
    pop_pend = tx_pop_o;
    req_s = bus_req_o; op_s = bus_op_o; wd_s = bus_wdata_o; ack_s = bus_ack_o;
    if (rx_push_o) begin if (n_rx < 64) rx_log[n_rx] = rx_data_o; n_rx++; end
    if (done_o) n_done++;
    if (nack_o) n_nack++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic chk_op(input string req, input int i, input int op, input int wd);
    chk_eq(req, int'(op_log[i]), op);
    if (op == 3) chk_eq(req, int'(wd_log[i]), wd);
  endtask

  function automatic logic [15:0] mk_cmd(input int alen, input bit rs, input int ralen,
                                         input bit dce, input bit nl, input bit se);
    return {1'b1, 3'b000, 1'b1, se, nl, dce, 3'(ralen), rs, 3'(alen), 1'b1};
  endfunction

  task automatic clear_logs();
    n_ops = 0; n_rx = 0; n_done = 0; n_nack = 0; wr_idx = 0; rd_idx = 0; nack_at = -1;
    txq.delete();
  endtask

  task automatic issue(input logic [15:0] c, input int dc, input bit ign);
    @(negedge clk);
    cmd_i = c; dcnt_i = DCNT_W'(dc); ign_nack_i = ign; cmd_valid_i = 1;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk_eq("R1 reset busy", busy_o, 0);
    chk_eq("R1 reset req", bus_req_o, 0);
    chk_eq("R13 reset done", done_o, 0);
  endtask

  task automatic t_write();
    clear_logs();
    txq = '{8'hA0, 8'h11, 8'h22, 8'h33};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 3, 0);
    wait_idle();
    chk_eq("R2 write op count", n_ops, 6);
    chk_op("R2 start first", 0, 1, 0);
    chk_op("R3 addr byte", 1, 3, 8'hA0);
    chk_op("R5 data0", 2, 3, 8'h11);
    chk_op("R5 data1", 3, 3, 8'h22);
    chk_op("R5 data2", 4, 3, 8'h33);
    chk_op("R9 stop", 5, 5, 0);
    chk_eq("R9 done", n_done, 1);
    chk_eq("R13 no nack", n_nack, 0);
    chk_eq("R5 fifo drained", txq.size(), 0);
  endtask

  task automatic t_read();
    clear_logs();
    txq = '{8'hA1};
    issue(mk_cmd(1, 0, 0, 1, 1, 1), 3, 0);
    wait_idle();
    chk_eq("R5 read op count", n_ops, 6);
    chk_op("R5 read op", 2, 4, 0);
    chk_op("R5 read op last", 4, 4, 0);
    chk_eq("R7 ack first", ack_log[2], 1);
    chk_eq("R7 ack mid", ack_log[3], 1);
    chk_eq("R7 nack last", ack_log[4], 0);
    chk_eq("R5 rx count", n_rx, 3);
    chk_eq("R5 rx0", rx_log[0], 8'h50);
    chk_eq("R5 rx2", rx_log[2], 8'h52);
    chk_eq("R9 read done", n_done, 1);
  endtask

  task automatic t_read_all_ack();
    clear_logs();
    txq = '{8'hA1};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 2, 0);
    wait_idle();
    chk_eq("R7 ack on last when bit9 clear", ack_log[3], 1);
  endtask

  task automatic t_combined();
    clear_logs();
    txq = '{8'hA0, 8'h05, 8'h06, 8'hA1};
    issue(mk_cmd(3, 1, 1, 1, 1, 1), 2, 0);
    wait_idle();
    chk_eq("R4 comb op count", n_ops, 9);
    chk_op("R3 comb addr", 1, 3, 8'hA0);
    chk_op("R3 comb reg0", 2, 3, 8'h05);
    chk_op("R3 comb reg1", 3, 3, 8'h06);
    chk_op("R4 rstart", 4, 2, 0);
    chk_op("R4 raddr", 5, 3, 8'hA1);
    chk_op("R5 comb read", 6, 4, 0);
    chk_eq("R7 comb last nack", ack_log[7], 0);
    chk_op("R9 comb stop", 8, 5, 0);
    chk_eq("R5 comb rx", n_rx, 2);
  endtask

  task automatic t_nack();
    clear_logs();
    nack_at = 0;
    txq = '{8'hA0, 8'h11, 8'h22};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 2, 0);
    wait_idle();
    chk_eq("R8 nack op count", n_ops, 3);
    chk_op("R8 stop after nack", 2, 5, 0);
    chk_eq("R8 nack pulse", n_nack, 1);
    chk_eq("R8 no done", n_done, 0);
  endtask

  task automatic t_ign_nack();
    clear_logs();
    nack_at = 1;
    txq = '{8'hA0, 8'h11, 8'h22};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 2, 1);
    wait_idle();
    chk_eq("R8 ignore op count", n_ops, 5);
    chk_eq("R8 ignore done", n_done, 1);
    chk_eq("R8 ignore no nack", n_nack, 0);
  endtask

  task automatic t_no_stop();
    clear_logs();
    txq = '{8'hA0, 8'h44};
    issue(mk_cmd(1, 0, 0, 1, 0, 0), 1, 0);
    wait_idle();
    chk_eq("R9 no-stop op count", n_ops, 3);
    chk_op("R9 last is write", 2, 3, 8'h44);
    chk_eq("R9 no-stop done", n_done, 1);
  endtask

  task automatic t_no_dcnt();
    clear_logs();
    txq = '{8'hA0, 8'h77};
    issue(mk_cmd(1, 0, 0, 0, 0, 1), 5, 0);
    wait_idle();
    chk_eq("R6 op count", n_ops, 3);
    chk_op("R6 stop after addr", 2, 5, 0);
    chk_eq("R6 data left", txq.size(), 1);
  endtask

  task automatic t_stall();
    clear_logs();
    txq = '{8'hA0};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 2, 0);
    repeat (20) @(negedge clk);
    #1;
    chk_eq("R10 stalled ops", n_ops, 2);
    chk_eq("R10 no request", bus_req_o, 0);
    chk_eq("R10 busy", busy_o, 1);
    @(negedge clk);
    txq.push_back(8'h61); txq.push_back(8'h62);
    wait_idle();
    chk_eq("R10 resumed ops", n_ops, 5);
    chk_op("R10 first data", 2, 3, 8'h61);
    chk_eq("R10 done", n_done, 1);
  endtask

  task automatic t_bad_cmd();
    clear_logs();
    txq = '{8'hA0};
    issue(mk_cmd(1, 0, 0, 1, 0, 1) & 16'h7FFF, 1, 0);
    repeat (5) @(negedge clk);
    #1;
    chk_eq("R1 no exec busy", busy_o, 0);
    issue(mk_cmd(1, 0, 0, 1, 0, 1) & 16'hF7FF, 1, 0);
    repeat (5) @(negedge clk);
    #1;
    chk_eq("R1 no ctl busy", busy_o, 0);
    issue(mk_cmd(1, 0, 0, 1, 0, 1) | 16'h2000, 1, 0);
    repeat (5) @(negedge clk);
    #1;
    chk_eq("R1 reserved set busy", busy_o, 0);
    chk_eq("R1 no ops", n_ops, 0);
    chk_eq("R1 fifo untouched", txq.size(), 1);
  endtask

  task automatic t_abort();
    int waited;
    clear_logs();
    txq = '{8'hA1};
    issue(mk_cmd(1, 0, 0, 1, 0, 1), 20, 0);
    for (int i = 0; i < 500 && n_ops < 4; i++) @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    waited = 0;
    for (int i = 0; i < 50 && busy_o; i++) begin @(negedge clk); waited++; end
    repeat (3) @(negedge clk);
    chk(waited <= 10, "R12 abort bound", waited, 10);
    chk_eq("R12 last op stop", int'(op_log[n_ops-1]), 5);
    chk(n_ops < 10, "R12 reads stopped", n_ops, 9);
    chk_eq("R12 no done", n_done, 0);
    chk_eq("R12 no nack", n_nack, 0);
  endtask

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write();
    t_read();
    t_read_all_ack();
    t_combined();
    t_nack();
    t_ign_nack();
    t_no_stop();
    t_no_dcnt();
    t_stall();
    t_bad_cmd();
    t_abort();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule